// File: doc/BRIEF.md
# Programmable-Order Sinc Decimator with Averaging Integrator

This block turns a one-bit oversampled stream, such as the output of a sigma-delta modulator that a channel receiver has already recovered, into signed multi-bit results at a much lower rate. Each accepted bit counts as +1 when it is 1 and as -1 when it is 0. A cascade of running-sum stages at the bit rate feeds difference stages that run once every FOSR bits, which forms a sinc filter of programmable order. An integrate-and-dump stage then adds IOSR consecutive sinc outputs and emits the sum as one result.

Software sets the order, the two ratios and a fast-mode flag while `enable` is low. Raising `enable` starts from a cleared state. In normal mode the first result waits until every sinc output it contains has been formed from a full window of real input. In fast mode results come on a fixed grid of FOSR*IOSR bits from the start, so the first one can be partly unsettled. One order code selects a reduced filter that acts as a second-order sinc with doubled gain. The largest result magnitude is m*FOSR^p*IOSR, with m = 2 for that reduced filter and m = 1 otherwise. Software keeps this below 2^31; results of about 24 bits are the usual aim.

Top module: `sinc_decim`

## Requirements
- R1: Once settled, a constant input of all 1s gives a result of m*FOSR^p*IOSR and a constant input of all 0s gives the negative of that value. Results are 32-bit two's complement on `resData`.
- R2: `orderSel` code 0 selects the reduced filter, which is a second-order sinc with its output doubled (p = 2, m = 2). Codes 1 to 5 select a sinc filter of that order (m = 1).
- R3: `fosrM1` holds FOSR-1, covering FOSR 1 to 1024. `iosrM1` holds IOSR-1, covering IOSR 1 to 256.
- R4: In normal mode with codes 1 to 5, the first result is produced by accepted bit number FOSR*(IOSR-1+p)+p, counted from 1 after `enable` rises.
- R5: In normal mode with code 0, the first result is produced by accepted bit number FOSR*(IOSR+3)+2.
- R6: With `fastMode` high, the first result is produced by accepted bit number FOSR*IOSR. In every mode, each later result follows the previous one by exactly FOSR*IOSR accepted bits.
- R7: For an input that repeats every FOSR bits and holds q ones per period, every settled result equals m*(2q-FOSR)*FOSR^(p-1)*IOSR.
- R8: While `enable` is low, or during reset, `resValid` stays low and all filter state is cleared. Each rise of `enable` restarts the bit count at zero.
- R9: A cycle with `bitValid` low does not change any result or the bit count, whatever `bitIn` carries in that cycle.
- R10: `resValid` is a one-cycle pulse on the second rising edge after the edge that accepts the bit that produces the result. `resData` changes only together with `resValid` and holds its value between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Run enable; low clears the filter and loads the configuration |
| bitValid | input | 1 | Qualifies `bitIn` in this cycle |
| bitIn | input | 1 | Modulator bit, 1 counts as +1 and 0 as -1 |
| orderSel | input | 3 | Filter order: 0 selects the doubled second-order filter, 1 to 5 select a sinc order |
| fosrM1 | input | 10 | Sinc decimation ratio minus one |
| iosrM1 | input | 8 | Integrator length minus one |
| fastMode | input | 1 | Produce results on the FOSR*IOSR grid from the first bit |
| resValid | output | 1 | Result strobe |
| resData | output | 32 | Signed result |

## Verification
The bench runs every order code in both modes against several ratio pairs and three input patterns. These are all ones, all zeros, and a stream that repeats every FOSR bits. It also runs three corner configurations: FOSR at 1024, IOSR at 256, and one whose result reaches 2^30. A decimation phase set up wrongly for the mode makes the first result appear a few bits too early or too late, and the index check reports it. A latency formula that ignores the order, or a dump that adds the wrong number of sinc outputs, gives a result that is off by a multiple of FOSR^(p-1). The comparison against the value worked out arithmetically exposes that error. Runs that insert an idle cycle with an inverted bit after every real bit show whether unqualified bits leak into the running sums.

// File: rtl/sinc_decim_pkg.sv
package sinc_decim_pkg;
  localparam int ORDER_W = 3;
  localparam logic [ORDER_W-1:0] FASTSINC_CODE = '0;

  // strobes issued by the control for the bit that was just accepted
  typedef struct packed {
    logic tick;   // decimation point: the difference stages run
    logic dump;   // this sinc output closes an averaging window
    logic clear;  // outside the first window: drop the partial sum
  } decimStrobe_t;
endpackage

// File: rtl/sinc_decim_ctrl.sv
module sinc_decim_ctrl
  import sinc_decim_pkg::*;
#(
  parameter int MAX_FOSR  = 1024,
  parameter int MAX_IOSR  = 256,
  parameter int MAX_ORDER = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        enable,
  input  logic                        bitValid,
  input  logic [ORDER_W-1:0]          orderSel,
  input  logic [$clog2(MAX_FOSR)-1:0] fosrM1,
  input  logic [$clog2(MAX_IOSR)-1:0] iosrM1,
  input  logic                        fastMode,
  output decimStrobe_t                strobe
);
  localparam int REM_W = $clog2(MAX_FOSR * (MAX_IOSR + MAX_ORDER) + MAX_ORDER + 1);
  localparam int MOD_STEPS = 1 << ORDER_W;

  logic [REM_W-1:0] fVal, iVal, pVal, fiVal, firstLat, base, rMod, initPhase;
  logic [REM_W-1:0] phase, phaseNext, rem, remNext;

  always_comb begin
    fVal  = REM_W'(fosrM1) + REM_W'(1);
    iVal  = REM_W'(iosrM1) + REM_W'(1);
    pVal  = REM_W'(orderSel);
    fiVal = fVal * iVal;
    if (fastMode) begin
      firstLat = fiVal;
      base     = '0;
    end else if (orderSel == FASTSINC_CODE) begin
      firstLat = fVal * (iVal + REM_W'(3)) + REM_W'(2);
      base     = REM_W'(2);
    end else begin
      firstLat = fVal * (iVal + pVal - REM_W'(1)) + pVal;
      base     = pVal;
    end
    // base is tiny, so a few conditional subtractions give base mod FOSR
    rMod = base;
    for (int k = 0; k < MOD_STEPS; k++) begin
      if (rMod >= fVal) rMod = rMod - fVal;
    end
    // start the phase so that decimation points land on the result bits
    initPhase = (rMod == '0) ? '0 : fVal - rMod;
    phaseNext = (phase == fVal - REM_W'(1)) ? '0 : phase + REM_W'(1);
    remNext   = rem - REM_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      phase  <= initPhase;
      rem    <= firstLat;
      strobe <= '0;
    end else begin
      strobe <= '0;
      if (bitValid) begin
        phase        <= phaseNext;
        strobe.tick  <= (phaseNext == '0);
        strobe.dump  <= (remNext == '0);
        strobe.clear <= (remNext >= fiVal);
        rem          <= (remNext == '0) ? fiVal : remNext;
      end
    end
  end
endmodule

// File: rtl/sinc_decim_datapath.sv
module sinc_decim_datapath
  import sinc_decim_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MAX_ORDER = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               bitValid,
  input  logic               bitIn,
  input  logic [ORDER_W-1:0] orderSel,
  input  decimStrobe_t       strobe,
  output logic               resValid,
  output logic [DATA_W-1:0]  resData
);
  logic signed [DATA_W-1:0] stepVal, integSel, sincOut, acc;
  logic signed [DATA_W-1:0] integ   [MAX_ORDER];
  logic signed [DATA_W-1:0] dly     [MAX_ORDER];
  logic signed [DATA_W-1:0] combOut [MAX_ORDER];
  int lastIdx;

  assign stepVal = bitIn ? DATA_W'(1) : '1;

  // running sums at the bit rate, wraparound arithmetic
  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      for (int k = 0; k < MAX_ORDER; k++) integ[k] <= '0;
    end else if (bitValid) begin
      integ[0] <= integ[0] + stepVal;
      for (int k = 1; k < MAX_ORDER; k++) integ[k] <= integ[k] + integ[k-1];
    end
  end

  always_comb begin
    if (orderSel == FASTSINC_CODE) lastIdx = 1;
    else if (int'(orderSel) > MAX_ORDER) lastIdx = MAX_ORDER - 1;
    else lastIdx = int'(orderSel) - 1;
    integSel = integ[lastIdx];
  end

  // difference stages evaluated at the decimated rate
  for (genvar k = 0; k < MAX_ORDER; k++) begin : gComb
    if (k == 0) begin : gFirst
      assign combOut[k] = integSel - dly[k];
    end else begin : gNext
      assign combOut[k] = combOut[k-1] - dly[k];
    end
  end

  assign sincOut = (orderSel == FASTSINC_CODE) ? (combOut[1] <<< 1) : combOut[lastIdx];

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      for (int k = 0; k < MAX_ORDER; k++) dly[k] <= '0;
      acc      <= '0;
      resValid <= 1'b0;
    end else begin
      resValid <= 1'b0;
      if (strobe.tick) begin
        dly[0] <= integSel;
        for (int k = 1; k < MAX_ORDER; k++) dly[k] <= combOut[k-1];
        if (strobe.dump) begin
          resValid <= 1'b1;
          acc      <= '0;
        end else if (strobe.clear) begin
          acc <= '0;
        end else begin
          acc <= acc + sincOut;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) resData <= '0;
    else if (enable && strobe.tick && strobe.dump) resData <= acc + sincOut;
  end
endmodule

// File: rtl/sinc_decim.sv
module sinc_decim
  import sinc_decim_pkg::*;
#(
  parameter int MAX_FOSR  = 1024,
  parameter int MAX_IOSR  = 256,
  parameter int MAX_ORDER = 5,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        enable,
  input  logic                        bitValid,
  input  logic                        bitIn,
  input  logic [ORDER_W-1:0]          orderSel,
  input  logic [$clog2(MAX_FOSR)-1:0] fosrM1,
  input  logic [$clog2(MAX_IOSR)-1:0] iosrM1,
  input  logic                        fastMode,
  output logic                        resValid,
  output logic [DATA_W-1:0]           resData
);
  decimStrobe_t strobe;

  sinc_decim_ctrl #(
    .MAX_FOSR(MAX_FOSR), .MAX_IOSR(MAX_IOSR), .MAX_ORDER(MAX_ORDER)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .bitValid(bitValid),
    .orderSel(orderSel), .fosrM1(fosrM1), .iosrM1(iosrM1),
    .fastMode(fastMode), .strobe(strobe)
  );

  sinc_decim_datapath #(
    .DATA_W(DATA_W), .MAX_ORDER(MAX_ORDER)
  ) uData (
    .clk(clk), .rstN(rstN), .enable(enable), .bitValid(bitValid),
    .bitIn(bitIn), .orderSel(orderSel), .strobe(strobe),
    .resValid(resValid), .resData(resData)
  );
endmodule

// File: rtl/sinc_decim_chk.sv
module sinc_decim_chk #(
  parameter int MAX_FOSR = 1024,
  parameter int MAX_IOSR = 256,
  parameter int DATA_W   = 32
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        enable,
  input logic                        bitValid,
  input logic [$clog2(MAX_FOSR)-1:0] fosrM1,
  input logic [$clog2(MAX_IOSR)-1:0] iosrM1,
  input logic                        resValid,
  input logic [DATA_W-1:0]           resData
);
  localparam int CNT_W = $clog2(MAX_FOSR * MAX_IOSR) + 2;

  logic [CNT_W-1:0] cnt, cntD, fiVal;
  assign fiVal = (CNT_W'(fosrM1) + CNT_W'(1)) * (CNT_W'(iosrM1) + CNT_W'(1));

  // accepted bits since enable rose, saturating
  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      cnt  <= '0;
      cntD <= '0;
    end else begin
      if (bitValid && cnt != '1) cnt <= cnt + CNT_W'(1);
      cntD <= cnt;
    end
  end

  // R8: no result while disabled
  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !resValid);

  // R10: result register moves only with its strobe
  a_r10_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> $stable(resData));

  // R9: every result traces back to an accepted bit two edges earlier
  a_r9_needs_bit: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(bitValid, 2));

  // R6: no result before FOSR*IOSR bits have been accepted
  a_r6_not_early: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (cntD >= fiVal));
endmodule

bind sinc_decim sinc_decim_chk #(
  .MAX_FOSR(MAX_FOSR), .MAX_IOSR(MAX_IOSR), .DATA_W(DATA_W)
) uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .bitValid(bitValid),
  .fosrM1(fosrM1), .iosrM1(iosrM1), .resValid(resValid), .resData(resData)
);

// File: tb/sim_sinc_decim.sv
module sim_sinc_decim;
  localparam int CLK_PERIOD = 10;
  localparam int NOUT = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        bitValid = 1'b0;
  logic        bitIn = 1'b0;
  logic [2:0]  orderSel = 3'd1;
  logic [9:0]  fosrM1 = '0;
  logic [7:0]  iosrM1 = '0;
  logic        fastMode = 1'b0;
  logic        resValid;
  logic [31:0] resData;

  int checks = 0, fails = 0;
  int sampled = 0, prevSampled = 0;
  int expIdx = 0, stepFI = 1, nOut = 0, settledFrom = 0;
  logic [31:0] expVal = '0;
  bit quiet = 1'b1;
  string timeTag = "R4", valTag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  sinc_decim u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .bitValid(bitValid), .bitIn(bitIn),
    .orderSel(orderSel), .fosrM1(fosrM1), .iosrM1(iosrM1), .fastMode(fastMode),
    .resValid(resValid), .resData(resData)
  );

  // one cycle: inspect outputs at the falling edge, then drive the next bit
  task automatic step(input logic v, input logic b);
    @(negedge clk);
    if (quiet) begin
      checks++;
      if (resValid) begin
        fails++;
        $display("FAIL R8 strobe while disabled: resValid=%0b expected 0", resValid);
      end
    end else if (resValid) begin
      checks++;
      if (prevSampled != expIdx) begin
        fails++;
        $display("FAIL %s/R10 result from bit %0d expected bit %0d", timeTag, prevSampled, expIdx);
      end
      if (prevSampled >= settledFrom) begin
        checks++;
        if (resData !== expVal) begin
          fails++;
          $display("FAIL %s R2 value ord=%0d got %0d expected %0d",
                   valTag, orderSel, $signed(resData), $signed(expVal));
        end
      end
      nOut++;
      expIdx += stepFI;
    end
    prevSampled = sampled;
    bitValid = v;
    bitIn = b;
    if (v && enable) sampled++;
  endtask

  function automatic logic patBit(int n, int f, int pat, int q);
    if (pat == 0) return 1'b1;
    if (pat == 1) return 1'b0;
    return (((n - 1) % f) < q);
  endfunction

  task automatic runCase(input int ord, input int f, input int i, input bit fast,
                         input int pat, input bit gap, input string tagV);
    int q, pe, lat, total;
    longint v;
    enable = 1'b0;
    quiet = 1'b1;
    orderSel = 3'(ord);
    fosrM1 = 10'(f - 1);
    iosrM1 = 8'(i - 1);
    fastMode = fast;
    step(0, 0);
    step(0, 0);
    q = (2 * f) / 3;
    pe = (ord == 0) ? 2 : ord;
    settledFrom = (ord == 0) ? f * (i + 3) + 2 : f * (i - 1 + ord) + ord;
    lat = fast ? f * i : settledFrom;
    v = (pat == 0) ? longint'(f) : (pat == 1) ? -longint'(f) : longint'(2 * q - f);
    for (int k = 1; k < pe; k++) v = v * f;
    v = v * i;
    if (ord == 0) v = v * 2;
    expVal = v[31:0];
    expIdx = lat;
    stepFI = f * i;
    nOut = 0;
    sampled = 0;
    prevSampled = 0;
    timeTag = fast ? "R6" : (ord == 0) ? "R5" : "R4";
    valTag = tagV;
    total = lat + (NOUT - 1) * f * i;
    enable = 1'b1;
    quiet = 1'b0;
    for (int n = 1; n <= total; n++) begin
      logic b;
      b = patBit(n, f, pat, q);
      step(1, b);
      if (gap) step(0, ~b);
    end
    for (int k = 0; k < 4; k++) step(0, 0);
    checks++;
    if (nOut != NOUT) begin
      fails++;
      $display("FAIL %s result count %0d expected %0d", timeTag, nOut, NOUT);
    end
    enable = 1'b0;
    quiet = 1'b1;
    step(0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog expired: finished=0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int fl [4];
    int il [4];
    fl = '{1, 2, 3, 4};
    il = '{1, 3, 2, 4};
    repeat (3) @(negedge clk);
    // R8: reset state
    checks++;
    if (resValid !== 1'b0 || resData !== 32'd0) begin
      fails++;
      $display("FAIL R8 reset state: resValid=%0b resData=%0h expected 0/0", resValid, resData);
    end
    rstN = 1'b1;
    // R8: bits offered while disabled produce nothing
    for (int k = 0; k < 12; k++) step(1, k[0]);

    // R1 R2 R4 R5 R6 R7 R9: sweep of orders, modes, ratios and patterns
    for (int ord = 0; ord <= 5; ord++)
      for (int fast = 0; fast <= 1; fast++)
        for (int c = 0; c < 4; c++)
          for (int pat = 0; pat <= 2; pat++)
            runCase(ord, fl[c], il[c], fast[0], pat, c == 3,
                    (c == 3) ? "R9" : (pat == 2) ? "R7" : "R1");

    // R3: ratio extremes and a large result
    runCase(1, 1024, 1, 1'b0, 0, 1'b0, "R3");
    runCase(2, 1024, 1, 1'b1, 2, 1'b0, "R3");
    runCase(3, 1, 256, 1'b0, 1, 1'b0, "R3");
    runCase(5, 32, 32, 1'b0, 0, 1'b0, "R1");
    runCase(5, 32, 32, 1'b0, 1, 1'b0, "R1");

    // R8: quiet after a run, then a restart behaves like a fresh start
    for (int k = 0; k < 8; k++) step(1, 1'b1);
    runCase(2, 3, 2, 1'b0, 0, 1'b0, "R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule